// File: doc/BRIEF.md
# Cache Lookup Statistics Counters

This block keeps two running tallies of cache lookup outcomes for performance monitoring: one for hits and one for misses. Each cycle the lookup logic may present a single hit or miss pulse, together with a flag saying whether the lookup came from a cacheable read. Only those qualified pulses advance a tally, and only while a local statistics-enable flag is set. That flag is held in the block and comes out of reset set to 1.

Software reaches the tallies through write and read strobes, one pair per counter. A write strobe carries no data and clears its counter to zero. A read strobe routes the selected count onto a shared read-data bus. Both counts are also available as separate outputs.

A build parameter removes the counters. In that build every access is still accepted. Reads return zero and writes change nothing.

Top module: `cache_stat_counters`

## Requirements
- R1: After reset, `hit_cnt_o`, `miss_cnt_o` and `rd_data_o` are 0, and `stat_en_o` is 1.
- R2: A cycle with `stat_en_o`=1, `lkp_cacheable_i`=1 and `lkp_hit_i`=1 (or `lkp_miss_i`=1) makes the hit (or miss) count one higher on the next clock edge. The other count is unchanged.
- R3: A hit or miss pulse with `lkp_cacheable_i`=0 leaves both counts unchanged.
- R4: `en_wr_i`=1 loads `en_wdata_i` into `stat_en_o` on the next edge. The new value governs counting from that edge onward.
- R5: While `stat_en_o`=0, both counts hold their value whatever lookups arrive.
- R6: `hit_wr_i` (or `miss_wr_i`) sets that counter to 0 on the next edge. The other counter is unaffected.
- R7: When a clearing write and a qualified increment hit the same counter in the same cycle, the counter becomes 0.
- R8: The counters wrap from 2^CNT_W-1 to 0 and do not saturate.
- R9: `rd_data_o` is combinational. It shows the hit count when `hit_rd_i`=1. It shows the miss count when only `miss_rd_i`=1. Otherwise it is 0.
- R10: With `HAS_CNT`=0, both counts and `rd_data_o` stay 0 under any stimulus. The enable flag still behaves as in R4.
- R11: `lkp_hit_i` and `lkp_miss_i` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lkp_hit_i | input | 1 | Lookup hit pulse |
| lkp_miss_i | input | 1 | Lookup miss pulse |
| lkp_cacheable_i | input | 1 | Lookup is a cacheable read |
| en_wr_i | input | 1 | Write strobe for the enable flag |
| en_wdata_i | input | 1 | New enable flag value |
| hit_wr_i | input | 1 | Clear the hit counter |
| miss_wr_i | input | 1 | Clear the miss counter |
| hit_rd_i | input | 1 | Select the hit count for readback |
| miss_rd_i | input | 1 | Select the miss count for readback |
| stat_en_o | output | 1 | Statistics enable flag |
| hit_cnt_o | output | CNT_W | Hit count |
| miss_cnt_o | output | CNT_W | Miss count |
| rd_data_o | output | CNT_W | Read data for the selected counter |

## Verification
The bench builds two copies side by side and drives both with the same stimulus. The first has `CNT_W`=8 and counters present. An 8-bit width lets a few hundred qualified hits carry the count past its top value, so the wrap in R8 is exercised within a short run. The second keeps the 32-bit default with `HAS_CNT`=0. This shows that the same lookups, clears and reads all leave the outputs at zero, while its enable flag still follows writes.

// File: rtl/cache_stat_pkg.sv
package cache_stat_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_HIT  = 2'd1,
    SEL_MISS = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;   // clear wins over increment
    else if (inc_i) cnt_o <= cnt_o + ONE;
  end

  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> cnt_o == W'($past(cnt_o) + ONE));
  a_r8_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_o == '1) |=> cnt_o == '0);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));
endmodule

// File: rtl/stat_rd_mux.sv
module stat_rd_mux
  import cache_stat_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         hit_rd_i,
  input  logic         miss_rd_i,
  input  logic [W-1:0] hit_cnt_i,
  input  logic [W-1:0] miss_cnt_i,
  output logic [W-1:0] rd_data_o
);
  rd_sel_e sel;

  always_comb begin
    if (hit_rd_i)       sel = SEL_HIT;
    else if (miss_rd_i) sel = SEL_MISS;
    else                sel = SEL_NONE;
  end

  always_comb begin
    unique case (sel)
      SEL_HIT:  rd_data_o = hit_cnt_i;
      SEL_MISS: rd_data_o = miss_cnt_i;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/cache_stat_counters.sv
module cache_stat_counters #(
  parameter int CNT_W   = 32,
  parameter bit HAS_CNT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_hit_i,
  input  logic             lkp_miss_i,
  input  logic             lkp_cacheable_i,
  input  logic             en_wr_i,
  input  logic             en_wdata_i,
  input  logic             hit_wr_i,
  input  logic             miss_wr_i,
  input  logic             hit_rd_i,
  input  logic             miss_rd_i,
  output logic             stat_en_o,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o,
  output logic [CNT_W-1:0] rd_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stat_en_o <= 1'b1;
    else if (en_wr_i) stat_en_o <= en_wdata_i;
  end

  a_r4_en_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> stat_en_o == $past(en_wdata_i));
  a_r11_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lkp_hit_i && lkp_miss_i));

  generate
    if (HAS_CNT) begin : g_cnt
      logic qual;
      assign qual = stat_en_o & lkp_cacheable_i;

      stat_counter #(.W(CNT_W)) u_hit (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (qual & lkp_hit_i),
        .clr_i (hit_wr_i),
        .cnt_o (hit_cnt_o)
      );

      stat_counter #(.W(CNT_W)) u_miss (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .inc_i (qual & lkp_miss_i),
        .clr_i (miss_wr_i),
        .cnt_o (miss_cnt_o)
      );

      a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stat_en_o && !hit_wr_i && !miss_wr_i) |=>
          ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
      a_r3_noncache: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lkp_cacheable_i && !hit_wr_i && !miss_wr_i) |=>
          ($stable(hit_cnt_o) && $stable(miss_cnt_o)));
    end else begin : g_none
      assign hit_cnt_o  = '0;
      assign miss_cnt_o = '0;
    end
  endgenerate

  stat_rd_mux #(.W(CNT_W)) u_rd (
    .hit_rd_i  (hit_rd_i),
    .miss_rd_i (miss_rd_i),
    .hit_cnt_i (hit_cnt_o),
    .miss_cnt_i(miss_cnt_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/cache_stat_counters_test.sv
module cache_stat_counters_test;
  localparam int W  = 8;
  localparam int WO = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 0, miss = 0, cach = 0, en_wr = 0, en_wd = 0;
  logic hwr = 0, mwr = 0, hrd = 0, mrd = 0;
  logic en_o, en_o_off;
  logic [W-1:0]  hc, mc, rd;
  logic [WO-1:0] hc_off, mc_off, rd_off;

  int checks = 0;
  int fails  = 0;
  int m_hit = 0, m_miss = 0, m_en = 1;
  bit done = 0;

  always #10 clk = ~clk;

  cache_stat_counters #(.CNT_W(W), .HAS_CNT(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_hit_i(hit), .lkp_miss_i(miss),
    .lkp_cacheable_i(cach), .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .hit_wr_i(hwr), .miss_wr_i(mwr), .hit_rd_i(hrd), .miss_rd_i(mrd),
    .stat_en_o(en_o), .hit_cnt_o(hc), .miss_cnt_o(mc), .rd_data_o(rd));

  cache_stat_counters #(.CNT_W(WO), .HAS_CNT(1'b0)) uut_off (
    .clk_i(clk), .rst_ni(rst_n), .lkp_hit_i(hit), .lkp_miss_i(miss),
    .lkp_cacheable_i(cach), .en_wr_i(en_wr), .en_wdata_i(en_wd),
    .hit_wr_i(hwr), .miss_wr_i(mwr), .hit_rd_i(hrd), .miss_rd_i(mrd),
    .stat_en_o(en_o_off), .hit_cnt_o(hc_off), .miss_cnt_o(mc_off),
    .rd_data_o(rd_off));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_rd();
    if (hrd) return m_hit;
    if (mrd) return m_miss;
    return 0;
  endfunction

  task automatic compare(input string req);
    chk(int'(hc) == m_hit, {req, " hit count"}, hc, m_hit);
    chk(int'(mc) == m_miss, {req, " miss count"}, mc, m_miss);
    chk(int'(en_o) == m_en, {req, " enable"}, en_o, m_en);
    chk(int'(rd) == exp_rd(), {req, " R9 read data"}, rd, exp_rd());
    // R10: counter-less build
    chk(hc_off == 0 && mc_off == 0, "R10 off counts", hc_off | mc_off, 0);
    chk(rd_off == 0, "R10 off read", rd_off, 0);
    chk(int'(en_o_off) == m_en, "R10 off enable", en_o_off, m_en);
  endtask

  // Inputs are already set at a negedge; advance one cycle and compare.
  task automatic step(input string req);
    int nh = m_hit, nm = m_miss, ne = m_en;
    if (hwr) nh = 0;
    else if (m_en == 1 && cach && hit) nh = (m_hit + 1) % (1 << W);
    if (mwr) nm = 0;
    else if (m_en == 1 && cach && miss) nm = (m_miss + 1) % (1 << W);
    if (en_wr) ne = int'(en_wd);
    @(posedge clk);
    @(negedge clk);
    m_hit = nh; m_miss = nm; m_en = ne;
    compare(req);
  endtask

  task automatic drive(input logic h, input logic m, input logic c);
    hit = h; miss = m; cach = c;
    en_wr = 0; hwr = 0; mwr = 0; hrd = 0; mrd = 0;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release");

    // R2: qualified hits and misses
    for (int i = 0; i < 5; i++) begin drive(1, 0, 1); step("R2 hit"); end
    for (int i = 0; i < 3; i++) begin drive(0, 1, 1); step("R2 miss"); end

    // R3: non-cacheable lookups ignored
    for (int i = 0; i < 4; i++) begin drive(i[0], !i[0], 0); step("R3 noncache"); end

    // R4/R5: disable, lookups while frozen, re-enable
    drive(1, 0, 1); en_wr = 1; en_wd = 0; step("R4 disable write");
    for (int i = 0; i < 4; i++) begin drive(i[0], !i[0], 1); step("R5 frozen"); end
    drive(0, 1, 1); en_wr = 1; en_wd = 1; step("R4 enable write");
    drive(0, 1, 1); step("R4 counting again");

    // R9: read selection, both strobes gives hit
    drive(0, 0, 0); hrd = 1; #1 chk(int'(rd) == m_hit, "R9 hit select", rd, m_hit);
    mrd = 1; #1 chk(int'(rd) == m_hit, "R9 both select", rd, m_hit);
    hrd = 0; #1 chk(int'(rd) == m_miss, "R9 miss select", rd, m_miss);
    step("R9 read");

    // R6: clear hit only, miss unaffected
    drive(0, 0, 0); hwr = 1; step("R6 clear hit");
    drive(1, 0, 1); step("R6 count after clear");
    drive(0, 1, 1); mwr = 1; step("R7 clear beats miss increment");
    drive(1, 0, 1); hwr = 1; step("R7 clear beats hit increment");

    // R8: wrap past 2^W-1
    for (int i = 0; i < 300; i++) begin drive(1, 0, 1); step("R8 wrap run"); end
    chk(m_hit == 300 % 256, "R8 model wrapped", m_hit, 300 % 256);

    // mixed traffic; R11: hit and miss never driven together
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 31);
      drive(r[0], !r[0] && r[1], r[2] | r[3]);
      hwr = (r == 5); mwr = (r == 9);
      en_wr = (r >= 28); en_wd = r[0];
      hrd = r[4]; mrd = r[3];
      #1 chk(int'(rd) == exp_rd(), "R9 mixed read", rd, exp_rd());
      step("R2 mixed");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule